// File: doc/BRIEF.md
# Low-Power Clock Source Select Register

This block is a single control register on a simple register bus. It chooses which of eight clock sources feeds a group of system clock domains. It holds three 4-bit source fields:

- a **current** field, which drives the active select;
- a **sleep** field, naming the source used for the bus clocks while the core clock is stopped;
- a **wake** field, naming the source used for the core and bus clocks after the system wakes.

Software writes the fields in privileged mode only. Two single-cycle hardware event pulses reload the current field. A "core clock off" pulse loads it from the sleep field. A "wakeup" pulse loads it from the wake field.

The block drives a 3-bit select toward an external glitch-free clock multiplexer. It also drives a sticky error flag. The flag sets when software stores an encoding outside the eight defined sources. When the current field holds such an encoding, the select keeps its last legal value. The multiplexer itself is outside the block.

Top module: `clksrc_sel_reg`

## Requirements
- R1: After reset every field is zero, `src_sel` is 0, `enc_err` is 0 and `bus_rdata` is zero.
- R2: A write with `bus_wr`=1, `bus_priv`=1 and `bus_addr`=0x48 stores `bus_wdata[27:24]` as the wake field, `[19:16]` as the sleep field and `[3:0]` as the current field. All other data bits are discarded.
- R3: A write with `bus_priv`=0 changes no field, and the change is visible on a later read.
- R4: A write to any address other than 0x48 changes no field. A read of any other address returns zero.
- R5: A pulse on `evt_clk_off` loads the current field from the sleep field. `src_sel` shows the new source in the following cycle.
- R6: A pulse on `evt_wake` loads the current field from the wake field.
- R7: When `evt_wake` and `evt_clk_off` are high in the same cycle, the wake field is loaded.
- R8: When an event and an accepted write occur in the same cycle:
  - the current field takes the event value, using the sleep or wake field as it stood before that cycle;
  - the sleep and wake fields still take the written data.
- R9: An accepted write that places a value 0x8–0xF in any field stores that value and sets `enc_err`. `enc_err` then stays 1 until reset.
- R10: Values 0x0–0x7 name sources 0–7. While the current field holds 0x8–0xF, `src_sel` keeps its last legal value. Otherwise `src_sel` equals the current field.
- R11: `bus_rdata` returns the register image, with every reserved bit zero, one cycle after a read at 0x48. The image holds the contents from before that cycle. `bus_rdata` is zero in any cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is in privileged mode |
| bus_rdata | output | 32 | Read data, one cycle after the read strobe |
| evt_clk_off | input | 1 | Single-cycle pulse: core clock turned off |
| evt_wake | input | 1 | Single-cycle pulse: system wakeup |
| src_sel | output | 3 | Active clock source select |
| enc_err | output | 1 | Sticky flag: a reserved encoding was written |

## Verification
The reload path is driven with each event pulse alone, with both pulses together, and with an event in the same cycle as a privileged write. The write carries a current-field value that differs from the event value, so the bench can tell which source won.

Writes are repeated with the privilege flag low and with a neighbouring address. Each is followed by a read, which separates the access qualifier from address decoding.

Reserved encodings reach the current field both by a write and by a sleep-field reload. The bench then checks that the select holds its last legal value and that the error flag stays set after later legal writes.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;

  // Which update wins a field register in a given cycle
  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_SW   = 2'd1,
    LD_HW   = 2'd2
  } ld_src_e;

endpackage

// File: rtl/clksrc_field.sv
module clksrc_field
  import clksrc_pkg::*;
#(
  parameter int unsigned W    = 4,
  parameter int unsigned NSRC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [W-1:0] sw_val,
  input  logic         hw_we,
  input  logic [W-1:0] hw_val,
  output logic [W-1:0] q,
  output logic         sw_bad
);

  localparam logic [W:0] LIM = (W+1)'(NSRC);

  ld_src_e      ld;
  logic         en;
  logic [W-1:0] d;
  logic [W-1:0] q_r;

  // Hardware reload outranks software
  always_comb begin
    if (hw_we)      ld = LD_HW;
    else if (sw_we) ld = LD_SW;
    else            ld = LD_NONE;
  end

  always_comb begin
    en = 1'b0;
    d  = q_r;
    unique case (ld)
      LD_HW:   begin en = 1'b1; d = hw_val; end
      LD_SW:   begin en = 1'b1; d = sw_val; end
      default: begin en = 1'b0; d = q_r;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= d;
  end

  assign q      = q_r;
  assign sw_bad = sw_we && ({1'b0, sw_val} >= LIM);

  // R8
  hw_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_we |=> (q == $past(hw_val)));

endmodule

// File: rtl/clksrc_evt.sv
module clksrc_evt #(
  parameter int unsigned W = 4
) (
  input  logic         evt_wake,
  input  logic         evt_clk_off,
  input  logic [W-1:0] wake_val,
  input  logic [W-1:0] sleep_val,
  output logic         hw_we,
  output logic [W-1:0] hw_val
);

  // Wakeup outranks clock-off when both pulse together
  always_comb begin
    hw_we  = evt_wake | evt_clk_off;
    hw_val = evt_wake ? wake_val : sleep_val;
  end

endmodule

// File: rtl/clksrc_selhold.sv
module clksrc_selhold #(
  parameter int unsigned W     = 4,
  parameter int unsigned NSRC  = 8,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     cur,
  output logic [SEL_W-1:0] sel
);

  localparam logic [W:0] LIM = (W+1)'(NSRC);

  logic             legal;
  logic             en;
  logic [SEL_W-1:0] last_d;
  logic [SEL_W-1:0] last_q;

  always_comb begin
    legal  = ({1'b0, cur} < LIM);
    sel    = legal ? cur[SEL_W-1:0] : last_q;
    en     = legal;
    last_d = cur[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  last_q <= '0;
    else if (en) last_q <= last_d;
  end

  // R10
  sel_hold_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!legal) |-> (sel == last_q));

endmodule

// File: rtl/clksrc_rdport.sv
module clksrc_rdport #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              rd_any,
  input  logic [DATA_W-1:0] img,
  output logic [DATA_W-1:0] rdata
);

  logic              busy_q;
  logic              en;
  logic [DATA_W-1:0] d;
  logic [DATA_W-1:0] rdata_q;

  // Clock only on a read strobe or to clear the previous return
  always_comb begin
    en = rd_any | busy_q;
    d  = rd_hit ? img : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= rd_any;
      if (en) rdata_q <= d;
    end
  end

  assign rdata = rdata_q;

  // R11
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_any) |=> (rdata == '0));

endmodule

// File: rtl/clksrc_sel_reg.sv
module clksrc_sel_reg #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FLD_W     = 4,
  parameter int unsigned NSRC      = 8,
  parameter int unsigned REG_OFS   = 32'h48,
  parameter int unsigned WAKE_LSB  = 24,
  parameter int unsigned SLEEP_LSB = 16,
  parameter int unsigned CUR_LSB   = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [DATA_W-1:0]        bus_wdata,
  input  logic                     bus_priv,
  output logic [DATA_W-1:0]        bus_rdata,
  input  logic                     evt_clk_off,
  input  logic                     evt_wake,
  output logic [$clog2(NSRC)-1:0]  src_sel,
  output logic                     enc_err
);

  localparam int unsigned SEL_W = $clog2(NSRC);
  localparam logic [ADDR_W-1:0] OFS = ADDR_W'(REG_OFS);
  localparam logic [DATA_W-1:0] FMASK =
      (DATA_W'((1 << FLD_W) - 1) << WAKE_LSB) |
      (DATA_W'((1 << FLD_W) - 1) << SLEEP_LSB) |
      (DATA_W'((1 << FLD_W) - 1) << CUR_LSB);

  logic             hit;
  logic             wr_ok;
  logic [FLD_W-1:0] wake_q, sleep_q, cur_q;
  logic             bad_w, bad_s, bad_c;
  logic             hw_we;
  logic [FLD_W-1:0] hw_val;
  logic [DATA_W-1:0] img;
  logic             err_d, err_q, err_en;
  logic             zero_we;
  logic [FLD_W-1:0] zero_val;
  logic             unused_bits;

  always_comb begin
    hit      = (bus_addr == OFS);
    wr_ok    = bus_wr & bus_priv & hit;
    zero_we  = 1'b0;
    zero_val = '0;
  end

  assign unused_bits = ^(bus_wdata & ~FMASK);

  clksrc_field #(.W(FLD_W), .NSRC(NSRC)) u_wake (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wr_ok), .sw_val(bus_wdata[WAKE_LSB +: FLD_W]),
    .hw_we(zero_we), .hw_val(zero_val),
    .q(wake_q), .sw_bad(bad_w)
  );

  clksrc_field #(.W(FLD_W), .NSRC(NSRC)) u_sleep (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wr_ok), .sw_val(bus_wdata[SLEEP_LSB +: FLD_W]),
    .hw_we(zero_we), .hw_val(zero_val),
    .q(sleep_q), .sw_bad(bad_s)
  );

  clksrc_evt #(.W(FLD_W)) u_evt (
    .evt_wake(evt_wake), .evt_clk_off(evt_clk_off),
    .wake_val(wake_q), .sleep_val(sleep_q),
    .hw_we(hw_we), .hw_val(hw_val)
  );

  clksrc_field #(.W(FLD_W), .NSRC(NSRC)) u_cur (
    .clk(clk), .rst_n(rst_n),
    .sw_we(wr_ok), .sw_val(bus_wdata[CUR_LSB +: FLD_W]),
    .hw_we(hw_we), .hw_val(hw_val),
    .q(cur_q), .sw_bad(bad_c)
  );

  clksrc_selhold #(.W(FLD_W), .NSRC(NSRC), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .cur(cur_q), .sel(src_sel)
  );

  // Register image with reserved bits forced to zero
  always_comb begin
    img = '0;
    img[WAKE_LSB  +: FLD_W] = wake_q;
    img[SLEEP_LSB +: FLD_W] = sleep_q;
    img[CUR_LSB   +: FLD_W] = cur_q;
  end

  clksrc_rdport #(.DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .rd_hit(bus_rd & hit), .rd_any(bus_rd),
    .img(img), .rdata(bus_rdata)
  );

  // Sticky encoding error
  always_comb begin
    err_en = bad_w | bad_s | bad_c;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  assign enc_err = err_q;

  // R3
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_priv && !evt_wake && !evt_clk_off)
      |=> ($stable(cur_q) && $stable(wake_q) && $stable(sleep_q)));

  // R5
  clk_off_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clk_off && !evt_wake) |=> (cur_q == $past(sleep_q)));

  // R7
  wake_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake |=> (cur_q == $past(wake_q)));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err |=> enc_err);

  // R10
  sel_tracks_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q < FLD_W'(NSRC)) |-> (src_sel == cur_q[SEL_W-1:0]));

endmodule

// File: tb/clksrc_sel_reg_tb.sv
module clksrc_sel_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_wr, bus_rd, bus_priv;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        evt_clk_off, evt_wake;
  logic [2:0]  src_sel;
  logic        enc_err;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  clksrc_sel_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
    .bus_rdata(bus_rdata), .evt_clk_off(evt_clk_off), .evt_wake(evt_wake),
    .src_sel(src_sel), .enc_err(enc_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_priv = 0; bus_addr = '0; bus_wdata = '0;
    evt_clk_off = 0; evt_wake = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; idle();
    @(negedge clk); @(negedge clk); rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic p);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d; bus_priv = p;
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); d = bus_rdata; idle();
  endtask

  task automatic pulse(input logic off, input logic wk);
    @(negedge clk); evt_clk_off = off; evt_wake = wk;
    @(negedge clk); idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 sel", {29'd0, src_sel}, 0);
    chk("R1 err", {31'd0, enc_err}, 0);
    chk("R1 rdata idle", bus_rdata, 0);
    rd(12'h048, v);
    chk("R1 image", v, 0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    wr(12'h048, 32'hF5F3_0F72, 1);
    rd(12'h048, v);
    chk("R2 image", v, 32'h0503_0002);
    chk("R2 sel", {29'd0, src_sel}, 2);
    chk("R2 err", {31'd0, enc_err}, 0);
    @(negedge clk);
    chk("R11 idle after read", bus_rdata, 0);
  endtask

  task automatic t_user();
    logic [31:0] v;
    wr(12'h048, 32'h0107_0006, 0);
    rd(12'h048, v);
    chk("R3 image", v, 32'h0503_0002);
    chk("R3 sel", {29'd0, src_sel}, 2);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(12'h04C, 32'h0107_0006, 1);
    rd(12'h04C, v);
    chk("R4 other read", v, 0);
    rd(12'h048, v);
    chk("R4 image", v, 32'h0503_0002);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(1, 0);
    chk("R5 sel", {29'd0, src_sel}, 3);
    rd(12'h048, v);
    chk("R5 image", v, 32'h0503_0003);
    pulse(0, 1);
    chk("R6 sel", {29'd0, src_sel}, 5);
    wr(12'h048, 32'h0601_0005, 1);
    pulse(1, 1);
    chk("R7 sel", {29'd0, src_sel}, 6);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    bus_wr = 1; bus_priv = 1; bus_addr = 12'h048; bus_wdata = 32'h0704_0002;
    evt_clk_off = 1;
    @(negedge clk); idle();
    rd(12'h048, v);
    chk("R8 image", v, 32'h0704_0001);
    chk("R8 sel", {29'd0, src_sel}, 1);
  endtask

  task automatic t_reserved();
    logic [31:0] v;
    wr(12'h048, 32'h0004_000A, 1);
    chk("R9 err set", {31'd0, enc_err}, 1);
    chk("R10 sel hold on write", {29'd0, src_sel}, 1);
    rd(12'h048, v);
    chk("R9 stored", v, 32'h0004_000A);
    wr(12'h048, 32'h0009_0003, 1);
    chk("R9 sticky", {31'd0, enc_err}, 1);
    chk("R10 sel legal", {29'd0, src_sel}, 3);
    pulse(1, 0);
    chk("R10 sel hold on reload", {29'd0, src_sel}, 3);
    rd(12'h048, v);
    chk("R10 image", v, 32'h0009_0009);
    pulse(0, 1);
    chk("R6 wake to zero", {29'd0, src_sel}, 0);
  endtask

  initial begin
    rst_n = 0; idle();
    do_reset();
    t_reset();
    t_write();
    t_user();
    t_addr();
    t_events();
    t_collide();
    t_reserved();
    do_reset();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule